// File: doc/BRIEF.md
# Flash Program and Erase Control Registers

This block sits between a 32-bit register bus and the command port of an embedded flash array. Software reaches a small window of control and status registers, and a separate flash address range where halfword stores become program operations. Every change to the array is guarded by a two-key unlock sequence. A wrong key shuts the block until the next reset.

Software first unlocks the block. It then picks an operation in the control register: page erase, with the page given by any address inside it loaded into the address register, or mass erase. Writing the start bit launches the operation. For programming, software sets the program-enable bit and stores halfwords into the flash range, one store per operation. The block issues one command pulse per operation to the array, holds the busy flag until the array answers done, and then raises an end-of-operation flag. Misuse sets sticky error flags that software clears by writing 1.

Register offsets, all in the register half of the bus address space (`bus_addr[ADDR_W-1]` = 0): access control 0x00, key 0x04, status 0x0C, control 0x10, address 0x14, option 0x1C, protection 0x20. A bus address with `bus_addr[ADDR_W-1]` = 1 lies in the flash range.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset the control register (0x10) reads 0x80 (lock bit 7 set, all else 0), the status register (0x0C) reads 0, and `fl_cmd_valid` is low.
- R2: A write of 0x45670123 to the key register (0x04), followed by a key write of 0xCDEF89AB, clears the lock, so the control register reads bit 7 = 0.
- R3: Once the block is locked for good, only a reset unlocks it again; a later correct pair of keys leaves bit 7 set. It locks for good on a wrong first key, on a wrong second key, or on any key write while it is unlocked.
- R4: While the lock is set, control register writes have no effect (the register still reads 0x80 from reset) and issue no command.
- R5: Writing control bit 7 = 1 while unlocked and idle sets the lock again, and a fresh correct key pair clears it.
- R6: Page erase: a control write with bit 1 (page) and bit 6 (start) set, and bit 2 clear, issues one command of code 1. The command carries the halfword address `addr_reg[ADDR_W-2:1]`. Status bit 0 (busy) and control bit 6 then read 1 until `fl_done`. After that, busy and start read 0 and status bit 5 (end of operation) reads 1. A start with both bits 1 and 2 set issues no command.
- R7: Mass erase: a control write with bit 2 and bit 6 set, and bit 1 clear, issues one command of code 2 and finishes like R6.
- R8: With control bit 0 (program enable) set and the block unlocked, a bus write to the flash range issues one command of code 3. The command carries halfword address `bus_addr[ADDR_W-2:1]` and data `bus_wdata[15:0]`. Status bit 0 stays set until `fl_done`.
- R9: A flash-range write issues no command when it is rejected. With program enable clear it sets status bit 2. With the lock set it sets status bit 4.
- R10: Writing 1 to status bits 2, 4 or 5 clears that bit, and writing 0 to it leaves it unchanged.
- R11: While busy, writes to the control register, the address register and the flash range are ignored: no command, no error, and both registers read their earlier values.
- R12: The access-control and key registers read 0, the option register reads `OPT_VALUE` and the protection register reads `WRP_VALUE`. Every bus request is answered by `bus_ready` in the next cycle, with read data valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address; top bit selects the flash range |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completed, one cycle after the request |
| fl_cmd_valid | output | 1 | One-cycle command pulse to the array |
| fl_cmd | output | 2 | 1 page erase, 2 mass erase, 3 program halfword |
| fl_addr | output | ADDR_W-2 | Halfword address of the command |
| fl_data | output | 16 | Halfword to program |
| fl_done | input | 1 | Array finished the current command |

## Verification
A wrong state in the key sequence shows up in the lock bit of the control register on the very next read. It also shows up as a command pulse that should not appear, or one that fails to appear, on the command port within one cycle of the start write. A busy flag that is stuck or released early shows up as extra or missing commands when software writes during an operation, and as a status value that does not match. A misrouted address shows in the address carried by the command. The expected command stream is compared pulse by pulse, so a dropped, doubled or wrongly coded operation is seen at the pulse where it goes wrong.

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs #(
  parameter int          ADDR_W    = 16,
  parameter logic [31:0] OPT_VALUE = 32'h00FF_0003,
  parameter logic [31:0] WRP_VALUE = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  output logic              fl_cmd_valid,
  output logic [1:0]        fl_cmd,
  output logic [ADDR_W-3:0] fl_addr,
  output logic [15:0]       fl_data,
  input  logic              fl_done
);
  localparam int OW = ADDR_W - 1;
  localparam logic [OW-1:0] OFS_ACR = OW'(8'h00);
  localparam logic [OW-1:0] OFS_KEY = OW'(8'h04);
  localparam logic [OW-1:0] OFS_SR  = OW'(8'h0C);
  localparam logic [OW-1:0] OFS_CR  = OW'(8'h10);
  localparam logic [OW-1:0] OFS_AR  = OW'(8'h14);
  localparam logic [OW-1:0] OFS_OPT = OW'(8'h1C);
  localparam logic [OW-1:0] OFS_WRP = OW'(8'h20);
  localparam logic [31:0] KEY_A = 32'h4567_0123;
  localparam logic [31:0] KEY_B = 32'hCDEF_89AB;
  localparam logic [1:0] CMD_PAGE = 2'd1;
  localparam logic [1:0] CMD_ALL  = 2'd2;
  localparam logic [1:0] CMD_PROG = 2'd3;

  typedef enum logic [1:0] {K_WAIT1, K_WAIT2, K_OPEN, K_DEAD} kstate_t;

  kstate_t     kst;
  logic        pg, per, mer, strt;
  logic        busy, eop, err_pg, err_wp;
  logic [31:0] addr_reg;
  logic [31:0] rd_val;

  wire          in_flash = bus_addr[ADDR_W-1];
  wire [OW-1:0] ofs      = bus_addr[OW-1:0];
  wire          wr       = bus_req & bus_we;
  wire          wr_reg   = wr & ~in_flash;
  wire          wr_key   = wr_reg & (ofs == OFS_KEY);
  wire          wr_sr    = wr_reg & (ofs == OFS_SR);
  wire          wr_cr    = wr_reg & (ofs == OFS_CR);
  wire          wr_ar    = wr_reg & (ofs == OFS_AR);
  wire          wr_fl    = wr & in_flash;

  wire locked   = (kst != K_OPEN);
  wire key_dead = (kst == K_DEAD);
  wire cr_ok    = wr_cr & ~locked & ~busy;
  wire start_er = cr_ok & bus_wdata[6] & (bus_wdata[1] ^ bus_wdata[2]);
  wire start_pg = wr_fl & ~busy & ~locked & pg;
  wire start    = start_er | start_pg;
  wire bad_pg   = wr_fl & ~busy & ~locked & ~pg;
  wire bad_wp   = wr_fl & ~busy & locked;
  wire finish   = busy & fl_done;

  wire [31:0] cr_val = {24'b0, locked, strt, 3'b0, mer, per, pg};
  wire [31:0] sr_val = {26'b0, eop, err_wp, 1'b0, err_pg, 1'b0, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kst <= K_WAIT1;
    end else if (wr_key && !key_dead) begin
      case (kst)
        K_WAIT1: kst <= (bus_wdata == KEY_A) ? K_WAIT2 : K_DEAD;
        K_WAIT2: kst <= (bus_wdata == KEY_B) ? K_OPEN : K_DEAD;
        default: kst <= K_DEAD;
      endcase
    end else if (cr_ok && bus_wdata[7]) begin
      kst <= K_WAIT1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg   <= 1'b0;
      per  <= 1'b0;
      mer  <= 1'b0;
      strt <= 1'b0;
    end else if (cr_ok) begin
      pg   <= bus_wdata[0];
      per  <= bus_wdata[1];
      mer  <= bus_wdata[2];
      strt <= start_er;
    end else if (finish) begin
      strt <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      eop    <= 1'b0;
      err_pg <= 1'b0;
      err_wp <= 1'b0;
    end else begin
      if (start)       busy <= 1'b1;
      else if (finish) busy <= 1'b0;
      if (finish)                     eop <= 1'b1;
      else if (wr_sr && bus_wdata[5]) eop <= 1'b0;
      if (bad_pg)                     err_pg <= 1'b1;
      else if (wr_sr && bus_wdata[2]) err_pg <= 1'b0;
      if (bad_wp)                     err_wp <= 1'b1;
      else if (wr_sr && bus_wdata[4]) err_wp <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr_reg <= '0;
    else if (wr_ar && !busy)   addr_reg <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_cmd_valid <= 1'b0;
      fl_cmd       <= 2'd0;
      fl_addr      <= '0;
      fl_data      <= '0;
    end else begin
      fl_cmd_valid <= start;
      if (start) begin
        fl_cmd  <= start_pg ? CMD_PROG : (bus_wdata[2] ? CMD_ALL : CMD_PAGE);
        fl_addr <= start_pg ? bus_addr[ADDR_W-2:1] : addr_reg[ADDR_W-2:1];
        fl_data <= bus_wdata[15:0];
      end
    end
  end

  always_comb begin
    case (ofs)
      OFS_ACR: rd_val = 32'b0;
      OFS_KEY: rd_val = 32'b0;
      OFS_SR:  rd_val = sr_val;
      OFS_CR:  rd_val = cr_val;
      OFS_AR:  rd_val = addr_reg;
      OFS_OPT: rd_val = OPT_VALUE;
      OFS_WRP: rd_val = WRP_VALUE;
      default: rd_val = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_req;
      if (bus_req && !bus_we) bus_rdata <= in_flash ? 32'b0 : rd_val;
    end
  end
endmodule

// File: rtl/flash_ctl_regs_chk.sv
module flash_ctl_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic bus_ready,
  input logic fl_cmd_valid,
  input logic fl_done,
  input logic busy,
  input logic locked,
  input logic key_dead,
  input logic eop
);
  AST_CMD_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid |-> !$past(locked)); // R4
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid |=> !fl_cmd_valid); // R6
  AST_CMD_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cmd_valid |-> busy); // R8
  AST_DONE_ENDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && fl_done) |=> (!busy && eop)); // R6
  AST_DEAD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    key_dead |=> (key_dead && locked)); // R3
  AST_READY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ready); // R12
endmodule

bind flash_ctl_regs flash_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ready(bus_ready),
  .fl_cmd_valid(fl_cmd_valid), .fl_done(fl_done), .busy(busy),
  .locked(locked), .key_dead(key_dead), .eop(eop)
);

// File: tb/flash_ctl_regs_bench.sv
module flash_ctl_regs_bench;
  localparam int          AW   = 16;
  localparam logic [31:0] OPTV = 32'h00FF_0003;
  localparam logic [31:0] WRPV = 32'hFFFF_FFFF;
  localparam int          LAT  = 20;
  localparam logic [15:0] A_ACR = 16'h00, A_KEY = 16'h04, A_SR = 16'h0C,
                          A_CR = 16'h10, A_AR = 16'h14, A_OPT = 16'h1C,
                          A_WRP = 16'h20, A_FL = 16'h8000;
  localparam logic [31:0] KA = 32'h4567_0123, KB = 32'hCDEF_89AB;

  logic clk = 0, rst_n = 0;
  logic bus_req = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ready, fl_cmd_valid, fl_done;
  logic [1:0] fl_cmd;
  logic [AW-3:0] fl_addr;
  logic [15:0] fl_data;
  int n_chk = 0, n_err = 0;

  logic [1:0]    q_cmd[$];
  logic [AW-3:0] q_addr[$];
  logic [15:0]   q_data[$];
  string         q_tag[$];

  always #4 clk = ~clk;

  flash_ctl_regs #(.ADDR_W(AW), .OPT_VALUE(OPTV), .WRP_VALUE(WRPV)) u_flash_ctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .fl_cmd_valid(fl_cmd_valid), .fl_cmd(fl_cmd),
    .fl_addr(fl_addr), .fl_data(fl_data), .fl_done(fl_done));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_cmd(input logic [1:0] c, input logic [AW-3:0] a,
                            input logic [15:0] d, input string tag);
    q_cmd.push_back(c); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && fl_cmd_valid) begin
      n_chk++;
      if (q_cmd.size() == 0) begin
        n_err++;
        $display("FAIL R4 unexpected command actual=%h expected=none", fl_cmd);
      end else begin
        logic [1:0] c; logic [AW-3:0] a; logic [15:0] d; string t;
        c = q_cmd.pop_front(); a = q_addr.pop_front();
        d = q_data.pop_front(); t = q_tag.pop_front();
        if (fl_cmd !== c || (c != 2'd2 && fl_addr !== a) || (c == 2'd3 && fl_data !== d)) begin
          n_err++;
          $display("FAIL %s command actual=%h/%h/%h expected=%h/%h/%h",
                   t, fl_cmd, fl_addr, fl_data, c, a, d);
        end
      end
    end
  end

  initial begin
    fl_done = 0;
    forever begin
      @(negedge clk);
      if (fl_cmd_valid) begin
        repeat (LAT) @(negedge clk);
        fl_done = 1;
        @(negedge clk);
        fl_done = 0;
      end
    end
  end

  task automatic bwr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  logic rdy_seen;
  task automatic brd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    d = bus_rdata; rdy_seen = bus_ready;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] e, input string tag);
    logic [31:0] v;
    brd(a, v);
    check(tag, v, e);
  endtask

  task automatic wait_idle;
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      brd(A_SR, v);
      if (!v[0]) break;
    end
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 cmd_valid after reset", {31'b0, fl_cmd_valid}, 0);
    rd_chk(A_CR, 32'h80, "R1 control reset");
    check("R12 ready", {31'b0, rdy_seen}, 1);
    rd_chk(A_SR, 32'h00, "R1 status reset");

    rd_chk(A_ACR, 32'h0, "R12 access reg");
    rd_chk(A_KEY, 32'h0, "R12 key reads zero");
    rd_chk(A_OPT, OPTV, "R12 option");
    rd_chk(A_WRP, WRPV, "R12 protection");

    bwr(A_CR, 32'h42);
    rd_chk(A_CR, 32'h80, "R4 control locked");
    bwr(A_FL, 32'h1111);
    rd_chk(A_SR, 32'h10, "R9 locked store error");
    bwr(A_SR, 32'h10);
    rd_chk(A_SR, 32'h00, "R10 clear bit4");

    bwr(A_KEY, KA); bwr(A_KEY, KB);
    rd_chk(A_CR, 32'h00, "R2 unlocked");

    bwr(A_FL, 32'h2222);
    rd_chk(A_SR, 32'h04, "R9 no program enable");
    bwr(A_SR, 32'h00);
    rd_chk(A_SR, 32'h04, "R10 write zero keeps");
    bwr(A_SR, 32'h04);
    rd_chk(A_SR, 32'h00, "R10 clear bit2");

    bwr(A_CR, 32'h46);
    rd_chk(A_CR, 32'h06, "R6 both erase bits no start");

    bwr(A_AR, 32'h0000_1234);
    expect_cmd(2'd1, 14'h091A, 16'h0, "R6");
    bwr(A_CR, 32'h42);
    bwr(A_AR, 32'h0000_5678);
    bwr(A_FL + 16'h10, 32'h3333);
    bwr(A_CR, 32'h44);
    rd_chk(A_CR, 32'h42, "R11 control kept while busy");
    rd_chk(A_AR, 32'h1234, "R11 address kept while busy");
    rd_chk(A_SR, 32'h01, "R6 busy during erase");
    wait_idle;
    rd_chk(A_SR, 32'h20, "R6 end of operation");
    rd_chk(A_CR, 32'h02, "R6 start cleared");
    bwr(A_SR, 32'h20);
    rd_chk(A_SR, 32'h00, "R10 clear bit5");

    expect_cmd(2'd2, 14'h0, 16'h0, "R7");
    bwr(A_CR, 32'h44);
    wait_idle;
    rd_chk(A_SR, 32'h20, "R7 end of operation");
    rd_chk(A_CR, 32'h04, "R7 start cleared");
    bwr(A_SR, 32'h20);

    bwr(A_CR, 32'h01);
    expect_cmd(2'd3, 14'h055E, 16'hBEEF, "R8");
    bwr(A_FL + 16'h0ABC, 32'hBEEF);
    rd_chk(A_SR, 32'h01, "R8 busy while programming");
    wait_idle;
    rd_chk(A_SR, 32'h20, "R8 program done");
    expect_cmd(2'd3, 14'h0001, 16'h1357, "R8");
    bwr(A_FL + 16'h0002, 32'h1357);
    wait_idle;

    bwr(A_CR, 32'h81);
    rd_chk(A_CR, 32'h81, "R5 relocked");
    bwr(A_FL, 32'h4444);
    rd_chk(A_SR, 32'h30, "R9 store after relock");
    bwr(A_KEY, KA); bwr(A_KEY, KB);
    rd_chk(A_CR, 32'h01, "R5 unlocked again");

    bwr(A_KEY, KA);
    rd_chk(A_CR, 32'h81, "R3 key write while open");
    bwr(A_KEY, KA); bwr(A_KEY, KB);
    rd_chk(A_CR, 32'h81, "R3 stays locked");
    bwr(A_CR, 32'h42);

    do_reset;
    bwr(A_KEY, 32'h1234_5678); bwr(A_KEY, KA); bwr(A_KEY, KB);
    rd_chk(A_CR, 32'h80, "R3 wrong first key");
    do_reset;
    bwr(A_KEY, KA); bwr(A_KEY, 32'h0); bwr(A_KEY, KA); bwr(A_KEY, KB);
    rd_chk(A_CR, 32'h80, "R3 wrong second key");
    do_reset;
    bwr(A_KEY, KA); bwr(A_KEY, KB);
    rd_chk(A_CR, 32'h00, "R3 reset ends lockout");

    repeat (4) @(negedge clk);
    check("R8 all commands seen", q_cmd.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule